// File: doc/BRIEF.md
# Two-Condition Input Capture Timer

This block is a single input-capture channel. A counter advances by one on each cycle where the external timer enable `tick` is high, provided the current counting mode lets it run. Two edge-watching inputs, called the start pin and the stop pin, pass through a synchronizer. Each pin's edge selector is set to disabled, rising, falling or either edge. A detected condition sets a status flag. Depending on its own enables, it may also raise the interrupt output and may copy the running count into a capture register.

Software programs the channel with one configuration write. It clears the counter with a separate command. Reading the status clears the flags. The capture value is read as two bytes: reading the low byte freezes the matching high byte in a holding register, so a new capture that lands between the two reads cannot tear the value. An overflow of the counter is flagged in status, but it never raises the interrupt.

Top module: `icap_channel`

## Requirements
- R1: When counting is allowed, `count` rises by exactly one on each clock where `tick` is high, and holds on every clock where `tick` is low.
- R2: Each condition has its own two-bit edge selector, `cfgData[3:2]` for start and `cfgData[5:4]` for stop. The codes are 00 disabled, 01 rising, 10 falling and 11 either edge. Only a selected edge on a tick cycle counts as a detection.
- R3: Each condition has its own controls. `cfgData[6]` (start) and `cfgData[7]` (stop) let the condition drive `irq`. `cfgData[8]` (start) and `cfgData[9]` (stop) let it capture the count. A detection with capture disabled leaves the capture register unchanged. The status flag is set whatever these enables are.
- R4: Mode 01 (`cfgData[1:0]`, gated): the counter is idle until a start detection. From the tick after the start detection it advances. On the stop detection it halts without counting that tick.
- R5: Mode 10 (free run): the counter advances on every tick. Detections only capture the count and set status. A capture takes the count value from before that tick's increment.
- R6: Mode 11 (run until stop): a configuration write selecting this mode starts counting. A stop detection halts it. It stays halted, and start detections are ignored, until the mode is written again.
- R7: The counter is cleared only by `ctrReset`. Configuration writes and wrap-around never clear it.
- R8: A tick that moves the counter from FFFFh to 0000h sets status bit 2. That bit never drives `irq`.
- R9: `capLo` shows the low byte of the capture register. A `lsbRd` pulse copies the capture register's high byte into a holding register, and `capHi` shows that holding register. It changes only on `lsbRd`.
- R10: `status` bit 0 flags a start detection, bit 1 a stop detection and bit 2 an overflow. A `statRd` pulse clears all flags. A flag set in the same cycle as the read survives.
- R11: A pin change that is stable before clock edge 1 is detected on the tick at edge 3 at the earliest, after the two-stage synchronizer. The status flag appears after that edge.
- R12: Mode 00 (disabled): the counter does not advance and neither condition is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable; counting and edge sampling happen only in such cycles |
| startPin | input | 1 | Asynchronous start-condition input |
| stopPin | input | 1 | Asynchronous stop-condition input |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 10 | Configuration: mode, edge selectors, interrupt and capture enables |
| ctrReset | input | 1 | Counter clear command |
| statRd | input | 1 | Status read strobe; clears the flags |
| lsbRd | input | 1 | Capture low-byte read strobe; loads the high-byte holder |
| count | output | 16 | Live counter value |
| capLo | output | 8 | Low byte of the capture register |
| capHi | output | 8 | Held high byte of the capture register |
| status | output | 3 | Flags: start, stop, overflow |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is the overflow flag: the counter has no load path, so the stimulus holds `tick` high for 65535 cycles after a clear, checks that the flag is still low at FFFFh, and then gives one more tick. The second is the torn read. Here the stimulus latches a count whose high byte is 01h, reads the low byte, then counts on until the high byte changes and fires a second capture before the high byte is read. The held byte must still be the old one. Edge selectors are walked from a table of code and direction pairs, with the pins resettled between entries so that the previous sample is known.

// File: rtl/icap_pkg.sv
package icap_pkg;

  localparam int CFG_W = 10;

  typedef enum logic [1:0] {
    MODE_OFF        = 2'b00,
    MODE_GATED      = 2'b01,
    MODE_FREE       = 2'b10,
    MODE_UNTIL_STOP = 2'b11
  } icMode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edgeSel_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic inc;
    logic clr;
    logic startHit;
    logic stopHit;
    logic latch;
    logic startIrqEn;
    logic stopIrqEn;
  } ctrlStrobe_t;

  function automatic logic edgeMatch(edgeSel_e sel, logic prevV, logic curV);
    logic rise;
    logic fall;
    rise = curV & ~prevV;
    fall = prevV & ~curV;
    case (sel)
      EDGE_RISE: edgeMatch = rise;
      EDGE_FALL: edgeMatch = fall;
      EDGE_ANY:  edgeMatch = rise | fall;
      default:   edgeMatch = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              startPin,
  input  logic              stopPin,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              ctrReset,
  output ctrlStrobe_t       strb
);

  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] pinVec;
  logic [NUM_PINS-1:0] syncOut;
  logic [NUM_PINS-1:0] prevSample;

  assign pinVec = {stopPin, startPin};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], pinVec[gi]};
      end
      assign syncOut[gi] = chain[SYNC_STAGES-1];
    end
  endgenerate

  // previous sample advances only on tick cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     prevSample <= '0;
    else if (tick) prevSample <= syncOut;
  end

  // configuration fields
  icMode_e  mode;
  edgeSel_e startSel;
  edgeSel_e stopSel;
  logic     startIrqEn, stopIrqEn, startLatchEn, stopLatchEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode         <= MODE_OFF;
      startSel     <= EDGE_NONE;
      stopSel      <= EDGE_NONE;
      startIrqEn   <= 1'b0;
      stopIrqEn    <= 1'b0;
      startLatchEn <= 1'b0;
      stopLatchEn  <= 1'b0;
    end else if (cfgWe) begin
      mode         <= icMode_e'(cfgData[1:0]);
      startSel     <= edgeSel_e'(cfgData[3:2]);
      stopSel      <= edgeSel_e'(cfgData[5:4]);
      startIrqEn   <= cfgData[6];
      stopIrqEn    <= cfgData[7];
      startLatchEn <= cfgData[8];
      stopLatchEn  <= cfgData[9];
    end
  end

  logic active;
  logic startHit, stopHit;

  assign active   = tick && (mode != MODE_OFF);
  assign startHit = active && edgeMatch(startSel, prevSample[0], syncOut[0]);
  assign stopHit  = active && edgeMatch(stopSel,  prevSample[1], syncOut[1]);

  // run flag for the gated and run-until-stop modes
  logic runFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFlag <= 1'b0;
    end else if (cfgWe) begin
      runFlag <= (icMode_e'(cfgData[1:0]) == MODE_UNTIL_STOP);
    end else begin
      case (mode)
        MODE_GATED: begin
          if (stopHit)       runFlag <= 1'b0;
          else if (startHit) runFlag <= 1'b1;
        end
        MODE_UNTIL_STOP: begin
          if (stopHit) runFlag <= 1'b0;
        end
        default: runFlag <= 1'b0;
      endcase
    end
  end

  logic incNow;
  always_comb begin
    case (mode)
      MODE_FREE:                   incNow = tick;
      MODE_GATED, MODE_UNTIL_STOP: incNow = tick && runFlag && !stopHit;
      default:                     incNow = 1'b0;
    endcase
  end

  assign strb.inc        = incNow;
  assign strb.clr        = ctrReset;
  assign strb.startHit   = startHit;
  assign strb.stopHit    = stopHit;
  assign strb.latch      = (startHit && startLatchEn) || (stopHit && stopLatchEn);
  assign strb.startIrqEn = startIrqEn;
  assign strb.stopIrqEn  = stopIrqEn;

  // R4: a stop detection in gated mode leaves the run flag cleared
  p_stop_halts_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_GATED) && stopHit && !cfgWe |=> !runFlag);

  // R6: once halted in run-until-stop mode, only a config write restarts it
  p_stay_halted_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_UNTIL_STOP) && !runFlag && !cfgWe |=> !runFlag);

  // R12: the disabled mode never produces an increment
  p_off_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> !strb.inc && !strb.latch);

endmodule

// File: rtl/icap_dpath.sv
module icap_dpath
  import icap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic               statRd,
  input  logic               lsbRd,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W/2-1:0] capLo,
  output logic [CNT_W/2-1:0] capHi,
  output logic [2:0]         status,
  output logic               irq
);

  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] capReg;
  logic [HALF-1:0]  holdHi;
  logic             wrapNow;

  assign wrapNow = strb.inc && !strb.clr && (count == FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         count <= '0;
    else if (strb.clr) count <= '0;
    else if (strb.inc) count <= count + ONE;
  end

  // capture takes the value before this tick's increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           capReg <= '0;
    else if (strb.latch) capReg <= count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      holdHi <= '0;
    else if (lsbRd) holdHi <= capReg[CNT_W-1:HALF];
  end

  logic [2:0] setBits;
  assign setBits = {wrapNow, strb.stopHit, strb.startHit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= setBits | (statRd ? 3'b000 : status);
  end

  assign irq   = (status[0] && strb.startIrqEn) || (status[1] && strb.stopIrqEn);
  assign capLo = capReg[HALF-1:0];
  assign capHi = holdHi;

  // R1: an increment strobe advances the count by exactly one
  p_inc_one_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.inc && !strb.clr |=> count == $past(count) + ONE);

  // R1: with no increment and no clear the count holds
  p_hold_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.inc && !strb.clr |=> $stable(count));

  // R8: wrap-around raises the overflow flag
  p_ovf_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.inc && !strb.clr && (count == FULL) |=> status[2] && (count == '0));

  // R9: the held high byte moves only on a low-byte read
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !lsbRd |=> $stable(capHi));

  // R10: a read with nothing new arriving empties the status
  p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    statRd && !strb.startHit && !strb.stopHit && !wrapNow |=> status == 3'b000);

endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               startPin,
  input  logic               stopPin,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               ctrReset,
  input  logic               statRd,
  input  logic               lsbRd,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W/2-1:0] capLo,
  output logic [CNT_W/2-1:0] capHi,
  output logic [2:0]         status,
  output logic               irq
);

  ctrlStrobe_t strb;

  icap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .startPin (startPin),
    .stopPin  (stopPin),
    .cfgWe    (cfgWe),
    .cfgData  (cfgData),
    .ctrReset (ctrReset),
    .strb     (strb)
  );

  icap_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .statRd (statRd),
    .lsbRd  (lsbRd),
    .count  (count),
    .capLo  (capLo),
    .capHi  (capHi),
    .status (status),
    .irq    (irq)
  );

  // R8: overflow alone never asks for an interrupt
  p_no_ovf_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (status[1:0] == 2'b00) |-> !irq);

endmodule

// File: tb/tb_icap_channel.sv
module tb_icap_channel;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {edge code[1:0], rising transition, expected detection}
  localparam logic [3:0] EDGE_VEC [NVEC] = '{
    4'b00_1_0, 4'b00_0_0, 4'b01_1_1, 4'b01_0_0,
    4'b10_1_0, 4'b10_0_1, 4'b11_1_1, 4'b11_0_1
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, startPin = 1'b0, stopPin = 1'b0;
  logic cfgWe = 1'b0, ctrReset = 1'b0, statRd = 1'b0, lsbRd = 1'b0;
  logic [9:0] cfgData = '0;
  logic [15:0] count;
  logic [7:0] capLo, capHi;
  logic [2:0] status;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icap_channel dut (
    .clk(clk), .rstN(rstN), .tick(tick), .startPin(startPin), .stopPin(stopPin),
    .cfgWe(cfgWe), .cfgData(cfgData), .ctrReset(ctrReset), .statRd(statRd),
    .lsbRd(lsbRd), .count(count), .capLo(capLo), .capHi(capHi),
    .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] mkCfg(input logic [1:0] md, input logic [1:0] se,
      input logic [1:0] pe, input logic si, input logic pi, input logic sl, input logic pl);
    return {pl, sl, pi, si, pe, se, md};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic writeCfg(input logic [9:0] v);
    cfgData = v; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseClr();
    ctrReset = 1'b1; @(negedge clk); ctrReset = 1'b0;
  endtask

  task automatic readStat();
    statRd = 1'b1; @(negedge clk); statRd = 1'b0;
  endtask

  task automatic readLsb();
    lsbRd = 1'b1; @(negedge clk); lsbRd = 1'b0;
  endtask

  // settle pins low and align the previous sample
  task automatic settle();
    startPin = 1'b0; stopPin = 1'b0;
    idle(3); ticks(1); readStat();
  endtask

  initial begin
    logic [7:0] savedLo;
    idle(2);
    rstN = 1'b1;
    idle(1);
    chk("R7 reset count", count, 16'h0);
    chk("R10 reset status", status, 3'b000);
    chk("R3 reset irq", irq, 1'b0);
    chk("R9 reset capHi", capHi, 8'h00);

    // R2: edge selector table, free-run mode, start interrupt enabled
    for (int i = 0; i < NVEC; i++) begin
      writeCfg(mkCfg(2'b10, EDGE_VEC[i][3:2], 2'b00, 1'b1, 1'b0, 1'b0, 1'b0));
      startPin = ~EDGE_VEC[i][1];
      idle(3); ticks(1); readStat();
      startPin = EDGE_VEC[i][1];
      idle(3); ticks(1);
      chk("R2 edge detect status", status[0], EDGE_VEC[i][0]);
      chk("R3 edge detect irq", irq, EDGE_VEC[i][0]);
    end
    settle();

    // R12: disabled mode
    writeCfg(mkCfg(2'b00, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1));
    pulseClr();
    ticks(5);
    chk("R12 off no count", count, 16'h0);
    startPin = 1'b1; idle(3); ticks(1);
    chk("R12 off no detect", status, 3'b000);
    settle();

    // R1 and R5: free run counts every tick, not between ticks
    writeCfg(mkCfg(2'b10, 2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0));
    pulseClr();
    ticks(9); idle(4);
    chk("R1 count per tick", count, 16'd9);
    startPin = 1'b1; idle(3); ticks(1);
    chk("R5 capture pre-increment", capLo, 8'd9);
    chk("R5 free run continues", count, 16'd10);
    settle();

    // R4: gated mode, start rising on startPin, stop rising on stopPin
    writeCfg(mkCfg(2'b01, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1));
    pulseClr();
    ticks(5);
    chk("R4 idle before start", count, 16'd0);
    startPin = 1'b1; idle(3); ticks(1);
    chk("R4 start tick not counted", count, 16'd0);
    ticks(7);
    chk("R4 counting after start", count, 16'd7);
    stopPin = 1'b1; idle(3); ticks(1);
    ticks(5);
    chk("R4 halted at stop", count, 16'd7);
    chk("R3 stop capture", capLo, 8'd7);
    chk("R10 both flags", status, 3'b011);
    readStat();
    chk("R10 cleared on read", status, 3'b000);
    settle();

    // R6 and R7: run until stop
    writeCfg(mkCfg(2'b11, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0));
    pulseClr();
    ticks(10);
    chk("R6 runs from enable", count, 16'd10);
    stopPin = 1'b1; idle(3); ticks(1); ticks(4);
    chk("R6 halted by stop", count, 16'd10);
    startPin = 1'b1; idle(3); ticks(3);
    chk("R6 start ignored", count, 16'd10);
    writeCfg(mkCfg(2'b11, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R7 config keeps count", count, 16'd10);
    ticks(2);
    chk("R6 resumes after rewrite", count, 16'd12);
    pulseClr();
    chk("R7 clear command", count, 16'd0);
    settle();

    // R3: capture and interrupt enables are per condition
    writeCfg(mkCfg(2'b10, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1));
    pulseClr();
    ticks(4);
    savedLo = capLo;
    startPin = 1'b1; idle(3); ticks(1);
    chk("R3 start no capture", capLo, savedLo);
    chk("R3 start irq", irq, 1'b1);
    readStat();
    stopPin = 1'b1; idle(3); ticks(1);
    chk("R3 stop flag", status, 3'b010);
    chk("R3 stop irq masked", irq, 1'b0);
    chk("R3 stop capture", capLo, 8'd5);
    settle();

    // R10: a detection coinciding with the read survives
    writeCfg(mkCfg(2'b10, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0));
    startPin = 1'b1; idle(3);
    tick = 1'b1; statRd = 1'b1; @(negedge clk); tick = 1'b0; statRd = 1'b0;
    chk("R10 set wins over clear", status[0], 1'b1);
    settle();

    // R11: synchronizer latency with tick held high
    tick = 1'b1; startPin = 1'b1;
    @(negedge clk);
    chk("R11 edge1 no flag", status[0], 1'b0);
    @(negedge clk);
    chk("R11 edge2 no flag", status[0], 1'b0);
    @(negedge clk);
    chk("R11 edge3 flag", status[0], 1'b1);
    tick = 1'b0;
    settle();

    // R9: held high byte against a second capture
    writeCfg(mkCfg(2'b10, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0));
    pulseClr();
    ticks(16'h0102);
    startPin = 1'b1; idle(3); ticks(1);
    chk("R9 low byte", capLo, 8'h02);
    readLsb();
    chk("R9 high byte held", capHi, 8'h01);
    ticks(16'h0200);
    startPin = 1'b0; idle(3); ticks(1);
    chk("R9 new low byte", capLo, 8'h03);
    chk("R9 high byte not torn", capHi, 8'h01);
    readLsb();
    chk("R9 high byte refreshed", capHi, 8'h03);
    settle();

    // R8: overflow flag, no interrupt
    writeCfg(mkCfg(2'b10, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0));
    pulseClr();
    ticks(65535);
    chk("R8 at all ones", count, 16'hFFFF);
    chk("R8 no flag yet", status[2], 1'b0);
    ticks(1);
    chk("R8 wrapped", count, 16'h0000);
    chk("R8 flag set", status[2], 1'b1);
    chk("R8 no irq", irq, 1'b0);
    ticks(3);
    chk("R7 no self reset", count, 16'd3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule